// File: doc/BRIEF.md
# Read-Strobe Delay Window Calibrator

This block centres a read-strobe delay line inside its passing window. On a start pulse it takes the tap value currently in use as its origin. It sweeps upward one tap at a time until a trial fails or the sweep reaches a fixed ceiling. It then goes back to the origin and sweeps downward until a trial fails or tap zero passes. From the last passing value in each direction it computes the midpoint. It drives the midpoint to the first byte lane and the midpoint plus one to the second lane.

Each trial works the same way. The trial value goes out on both lane tap outputs. A check request is then raised toward an external pattern checker, which answers later with a single pass/fail result.

The request channel is valid/ready. `chk_valid` stays high, with both lane taps held stable, until the cycle in which `chk_ready` is also high. That cycle is the handshake. The checker may stall for any number of cycles.

The result channel has no back-pressure. The block is always ready for a result while it waits for one, and it ignores `res_valid` at every other time.

Top module: `dqs_window_cal`

## Requirements
- R1: `start` is accepted only while `busy` is low. Acceptance sets `busy`, clears `done`, and makes the first trial equal to `init_tap`; a `start` pulse while `busy` is high has no effect on the sweep or its result.
- R2: During a sweep, `lane0_tap` and `lane1_tap` both carry the trial value. `chk_valid` stays high with the taps unchanged until `chk_ready`. Exactly one result per handshake is taken, and `res_valid` outside the wait for a result is ignored.
- R3: Sweeping upward, a pass at a value below TAP_LIMIT (default 32) makes the next trial that value plus one.
- R4: Sweeping upward, a pass at a value at or above TAP_LIMIT records upper = value, and the next trial is the origin, sweeping downward.
- R5: Sweeping upward, a failure records upper = value − 1 (0 if the value is 0), and the next trial is the origin, sweeping downward.
- R6: Sweeping downward, a pass at value 0 records lower = 0 and ends the sweep; a pass at a nonzero value makes the next trial that value minus one.
- R7: Sweeping downward, a failure records lower = value + 1 (saturating at 63) and ends the sweep.
- R8: At the end, `lane0_tap` = (upper + lower) / 2, truncated. `lane1_tap` = lane0 + 1, saturating at 63 (taps are 6 bits). `done` rises and `busy` falls.
- R9: After reset `done`, `busy`, `chk_valid` and both taps are 0. Once `done` is high, it and both taps stay unchanged regardless of `chk_ready` or `res_valid` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration (accepted when not busy) |
| init_tap | input | 6 | Tap value currently in use; sweep origin |
| chk_valid | output | 1 | Pattern check request valid |
| chk_ready | input | 1 | Checker accepts the request |
| res_valid | input | 1 | Check result valid |
| res_fail | input | 1 | Check result: 1 = mismatch |
| lane0_tap | output | 6 | Delay tap for byte lane 0 |
| lane1_tap | output | 6 | Delay tap for byte lane 1 |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Final taps valid |

## Verification
The bench models the external checker as a pass window [lo, hi] and tries several kinds of window:
- A window strictly inside the range, with the origin inside it, exercises both failure edges.
- Windows that run past the ceiling, or down to zero, separate the limit and zero stopping rules from the failure rules.
- Origins outside their window test the bound corrections at tap 0 and tap 63, and a window at 63 alone tests the lane-1 saturation.

Random windows and origins, with random checker stall and result latency, show that the search does not depend on handshake timing. A mid-sweep `start` and stray results after completion show that both are ignored.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CENTER,
    ST_DONE
  } cal_state_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sweep_dir_t;
endpackage

// File: rtl/dqs_cal_sweep.sv
module dqs_cal_sweep
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  input  logic             chk_ready,
  input  logic             res_valid,
  input  logic             res_fail,
  output logic [TAP_W-1:0] trial_tap,
  output logic [TAP_W-1:0] upper,
  output logic [TAP_W-1:0] lower,
  output logic             chk_valid,
  output logic             busy,
  output logic             sweep_end,
  output logic             done
);
  localparam logic [TAP_W-1:0] MAXV  = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] LIMIT = TAP_W'(TAP_LIMIT);

  cal_state_t       state_q;
  sweep_dir_t       dir_q;
  logic [TAP_W-1:0] origin_q, val_q, upper_q, lower_q;

  wire accept = start && (state_q == ST_IDLE || state_q == ST_DONE);
  wire result = res_valid && (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dir_q    <= DIR_UP;
      origin_q <= '0;
      val_q    <= '0;
      upper_q  <= '0;
      lower_q  <= '0;
    end else if (accept) begin
      state_q  <= ST_REQ;
      dir_q    <= DIR_UP;
      origin_q <= init_tap;
      val_q    <= init_tap;
      upper_q  <= init_tap;
      lower_q  <= init_tap;
    end else begin
      case (state_q)
        ST_REQ:    if (chk_ready) state_q <= ST_WAIT;
        ST_CENTER: state_q <= ST_DONE;
        ST_WAIT: if (result) begin
          if (dir_q == DIR_UP) begin
            if (!res_fail && val_q < LIMIT) begin
              val_q <= val_q + 1'b1;
            end else begin
              if (res_fail) upper_q <= (val_q == '0) ? '0 : val_q - 1'b1;
              else          upper_q <= val_q;
              val_q <= origin_q;
              dir_q <= DIR_DOWN;
            end
            state_q <= ST_REQ;
          end else begin
            if (res_fail) begin
              lower_q <= (val_q == MAXV) ? MAXV : val_q + 1'b1;
              state_q <= ST_CENTER;
            end else if (val_q == '0) begin
              lower_q <= '0;
              state_q <= ST_CENTER;
            end else begin
              val_q   <= val_q - 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign trial_tap = val_q;
  assign upper     = upper_q;
  assign lower     = lower_q;
  assign chk_valid = (state_q == ST_REQ);
  assign busy      = (state_q == ST_REQ) || (state_q == ST_WAIT) || (state_q == ST_CENTER);
  assign sweep_end = (state_q == ST_CENTER);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/dqs_cal_center.sv
module dqs_cal_center #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAP_W-1:0] upper,
  input  logic [TAP_W-1:0] lower,
  output logic [TAP_W-1:0] fin0,
  output logic [TAP_W-1:0] fin1
);
  localparam logic [TAP_W-1:0] MAXV = {TAP_W{1'b1}};

  logic [TAP_W:0]   sum;
  logic [TAP_W-1:0] mid;

  always_comb begin
    sum = {1'b0, upper} + {1'b0, lower};
    mid = sum[TAP_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin0 <= '0;
      fin1 <= '0;
    end else if (load) begin
      fin0 <= mid;
      fin1 <= (mid == MAXV) ? MAXV : mid + 1'b1;
    end
  end
endmodule

// File: rtl/dqs_window_cal.sv
module dqs_window_cal #(
  parameter int TAP_W     = 6,
  parameter int TAP_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  output logic             chk_valid,
  input  logic             chk_ready,
  input  logic             res_valid,
  input  logic             res_fail,
  output logic [TAP_W-1:0] lane0_tap,
  output logic [TAP_W-1:0] lane1_tap,
  output logic             busy,
  output logic             done
);
  logic [TAP_W-1:0] trial, upper, lower, fin0, fin1;
  logic             sweep_end;

  dqs_cal_sweep #(.TAP_W(TAP_W), .TAP_LIMIT(TAP_LIMIT)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start), .init_tap(init_tap),
    .chk_ready(chk_ready), .res_valid(res_valid), .res_fail(res_fail),
    .trial_tap(trial), .upper(upper), .lower(lower),
    .chk_valid(chk_valid), .busy(busy), .sweep_end(sweep_end), .done(done)
  );

  dqs_cal_center #(.TAP_W(TAP_W)) u_center (
    .clk(clk), .rst_n(rst_n), .load(sweep_end),
    .upper(upper), .lower(lower), .fin0(fin0), .fin1(fin1)
  );

  assign lane0_tap = done ? fin0 : trial;
  assign lane1_tap = done ? fin1 : trial;
endmodule

// File: rtl/dqs_cal_chk.sv
module dqs_cal_chk #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             chk_valid,
  input logic             chk_ready,
  input logic [TAP_W-1:0] lane0_tap,
  input logic [TAP_W-1:0] lane1_tap,
  input logic             busy,
  input logic             done
);
  localparam logic [TAP_W-1:0] MAXV = {TAP_W{1'b1}};

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_ready |=> chk_valid && $stable(lane0_tap) && $stable(lane1_tap));

  // R2
  req_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> busy && !done);

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  // R8
  lane1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lane1_tap == ((lane0_tap == MAXV) ? MAXV : lane0_tap + 1'b1));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(lane0_tap) && $stable(lane1_tap));
endmodule

bind dqs_window_cal dqs_cal_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chk_valid(chk_valid),
  .chk_ready(chk_ready), .lane0_tap(lane0_tap), .lane1_tap(lane1_tap),
  .busy(busy), .done(done)
);

// File: tb/dqs_window_cal_tb.sv
module dqs_window_cal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 32;
  localparam int MAXV       = 63;

  logic       clk = 0, rst_n = 0, start = 0, chk_ready = 0, res_valid = 0, res_fail = 0;
  logic [5:0] init_tap = 0;
  logic       chk_valid, busy, done;
  logic [5:0] lane0_tap, lane1_tap;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_window_cal u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .init_tap(init_tap),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .res_valid(res_valid),
    .res_fail(res_fail), .lane0_tap(lane0_tap), .lane1_tap(lane1_tap),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected final {lane0, lane1} from the search rules R3..R8
  function automatic int model(input int init, input int lo, input int hi);
    int v = init, up = init, low = init, mid, l1;
    bit dir_up = 1, fin = 0;
    while (!fin) begin
      bit pass = (v >= lo) && (v <= hi);
      if (dir_up) begin
        if (pass && v < LIMIT) v++;
        else begin
          up = pass ? v : ((v == 0) ? 0 : v - 1);
          v = init; dir_up = 0;
        end
      end else begin
        if (!pass) begin low = (v == MAXV) ? MAXV : v + 1; fin = 1; end
        else if (v == 0) begin low = 0; fin = 1; end
        else v--;
      end
    end
    mid = (up + low) / 2;
    l1  = (mid == MAXV) ? MAXV : mid + 1;
    return mid * 64 + l1;
  endfunction

  task automatic run_case(input int init, input int lo, input int hi,
                          input bit poke, input string tag);
    int  exp = model(init, lo, hi);
    int  guard = 0, trials = 0;
    int  tap;
    @(negedge clk);
    init_tap = 6'(init); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !done, "R1 busy after start", {busy, done}, 2);
    while (!done && guard < 4000) begin
      if (chk_valid) begin
        if (trials == 0) chk(lane0_tap == 6'(init), "R1 first trial", lane0_tap, init);
        chk(lane0_tap == lane1_tap, "R2 lanes equal", lane1_tap, lane0_tap);
        tap = lane0_tap;
        repeat ($urandom % 3) @(negedge clk);
        chk(chk_valid && lane0_tap == 6'(tap), "R2 hold under stall", lane0_tap, tap);
        chk_ready = 1;
        @(negedge clk);
        chk_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        res_valid = 1; res_fail = !(tap >= lo && tap <= hi);
        @(negedge clk);
        res_valid = 0; res_fail = 0;
        trials++;
        if (poke && trials == 1) begin
          init_tap = 6'(init ^ 6'h15); start = 1;
          @(negedge clk);
          start = 0; init_tap = 6'(init);
        end
      end else @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(done && !busy, {tag, " R8 done"}, {done, busy}, 2);
    chk(int'(lane0_tap) == exp / 64, {tag, " lane0"}, lane0_tap, exp / 64);
    chk(int'(lane1_tap) == exp % 64, {tag, " lane1"}, lane1_tap, exp % 64);
    // R9: stray handshake/result traffic after completion must not disturb taps
    for (int k = 0; k < 4; k++) begin
      chk_ready = k[0]; res_valid = 1; res_fail = k[1];
      @(negedge clk);
    end
    chk_ready = 0; res_valid = 0; res_fail = 0;
    chk(done && int'(lane0_tap) == exp / 64 && int'(lane1_tap) == exp % 64,
        "R9 hold after done", lane0_tap, exp / 64);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !chk_valid, "R9 reset flags", {done, busy, chk_valid}, 0);
    chk(lane0_tap == 0 && lane1_tap == 0, "R9 reset taps", lane0_tap, 0);
    rst_n = 1;
    run_case(10, 4, 20, 0, "R5 R7 inner window");
    run_case(30, 25, 63, 0, "R3 R4 ceiling");
    run_case(5, 0, 40, 0, "R4 R6 zero reached");
    run_case(40, 0, 63, 0, "R4 origin above ceiling");
    run_case(7, 10, 20, 0, "R5 R7 origin fails");
    run_case(0, 5, 9, 0, "R5 upper at zero");
    run_case(63, 0, 62, 0, "R7 lower saturates");
    run_case(63, 63, 63, 0, "R8 lane1 saturates");
    run_case(12, 6, 18, 1, "R1 start ignored while busy");
    for (int n = 0; n < 20; n++) begin
      int a = $urandom % 64, b = $urandom % 64, i = $urandom % 64;
      if (a > b) begin int t = a; a = b; b = t; end
      run_case(i, a, b, 0, "R3 R6 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule